// File: doc/BRIEF.md
# Per-Block Flash Protection State Manager

This block keeps the protection state of every erase block in a boot-block flash array: 8 small parameter blocks and 63 main blocks, 71 in all. Each block carries a lock bit and a lock-down bit. Decoded lock, unlock and lock-down requests arrive with a block index on a one-cycle strobe. A write-protect level decides whether locked-down blocks may be unlocked. A programming-voltage lockout flag refuses all program and erase work while it is asserted.

A query index selects one block. The block returns a status word and a program/erase permit for that block. The command decoder and the array control logic use these outputs to decide whether a program or erase may start. Reset puts every block back in the locked state.

Top module: `blk_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every block reports lock bit 1 and lock-down bit 0.
- R2: A strobed request with op 2'b01 sets the lock bit of the indexed block, and op 2'b10 clears it. The result is visible on the readout in the cycle after the strobe edge. Op 2'b00 changes nothing.
- R3: A strobed request with op 2'b11 sets both the lock-down bit and the lock bit of the indexed block, whatever the write-protect level.
- R4: No request clears a lock-down bit. Only reset clears it.
- R5: While wp_level is 0, a block with lock-down set ignores lock and unlock requests and reports lock bit 1.
- R6: While wp_level is 1, a locked-down block may be unlocked and relocked freely. Its lock-down bit stays 1.
- R7: When wp_level falls to 0, every locked-down block reports lock bit 1 in that same cycle and keeps it, whatever was done while wp_level was 1.
- R8: pe_ok is 1 only when the queried block's reported lock bit is 0.
- R9: While vpp_lockout is 1, pe_ok is 0 for every block. The lock bits are unchanged.
- R10: Status layout: bit 0 is the reported lock bit, bit 1 is the lock-down bit, and every other bit is 0.
- R11: Indices 71 to 127 are invalid. A query there returns status 0 and pe_ok 0. A request there changes no block.
- R12: A request changes only the block it indexes. All other blocks keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; returns all blocks to locked |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | 00 none, 01 lock, 10 unlock, 11 lock-down |
| req_idx | input | 7 | Block index of the request |
| wp_level | input | 1 | Write-protect level; 0 enforces lock-down |
| vpp_lockout | input | 1 | Programming-voltage lockout; 1 refuses all program/erase |
| qry_idx | input | 7 | Block index to report |
| stat_word | output | 16 | Status of the queried block |
| pe_ok | output | 1 | Program/erase permitted on the queried block |

## Verification
The bench builds the block with its defaults: 8 parameter blocks, 63 main blocks, a 7-bit index and a 16-bit status word. With these values both the parameter/main seam (indices 7 and 8) and the last valid block (70) can be reached. The index also spans 57 invalid codes (71 to 127), so random traffic often hits the invalid range with both requests and queries. Directed sequences step one block through the write-protect transitions and through the lockout. A long random run then mixes requests, write-protect toggles, lockout and occasional resets against a behavioural model.

// File: rtl/blk_guard_pkg.sv
// Package: shared request encoding for the block protection manager.
// Assumes: the op code is a 2-bit field decoded upstream.
package blk_guard_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOCK   = 2'b01,
        OP_UNLOCK = 2'b10,
        OP_LDOWN  = 2'b11
    } guard_op_t;

endpackage

// File: rtl/blk_guard_sel.sv
// Module: blk_guard_sel
// Turns a request strobe and block index into a one-hot write select.
// Assumes: indices at or above N_BLK select no block.
module blk_guard_sel #(
    parameter int N_BLK = 71,
    parameter int IDX_W = 7
) (
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    output logic [N_BLK-1:0] sel
);

    // One comparator per block: that block's write select.
    for (genvar i = 0; i < N_BLK; i++) begin : g_cmp
        assign sel[i] = req_valid && (req_idx == IDX_W'(i));
    end

    // At most one block is addressed; invalid indices address none.
    always_comb begin
        a_r12_sel_onehot: assert ($onehot0(sel));
        if (int'(req_idx) >= N_BLK)
            a_r11_invalid_no_sel: assert (sel == '0);
    end

endmodule

// File: rtl/blk_guard_cell.sv
// Module: blk_guard_cell
// Protection state for one erase block: lock bit and lock-down bit.
// Assumes: wr_en is already qualified by index match and strobe.
module blk_guard_cell
    import blk_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  guard_op_t op,
    input  logic      wp_level,
    output logic      lock_q,
    output logic      ld_q
);

    // State update: reset to locked, apply request, then re-lock enforced blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b1;
            ld_q   <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (op)
                    OP_LOCK:   lock_q <= 1'b1;
                    OP_UNLOCK: if (!ld_q || wp_level) lock_q <= 1'b0;
                    OP_LDOWN: begin
                        lock_q <= 1'b1;
                        ld_q   <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (ld_q && !wp_level)
                lock_q <= 1'b1;
        end
    end

    // R4: lock-down never clears outside reset.
    a_r4_ld_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |=> ld_q);

    // R3: lock-down request sets both bits.
    a_r3_ldown_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_LDOWN) |=> (ld_q && lock_q));

    // R2: lock request sets the lock bit.
    a_r2_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_LOCK) |=> lock_q);

    // R5: enforced lock-down leaves the stored lock bit set.
    a_r5_enforced: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q && !wp_level) |=> lock_q);

endmodule

// File: rtl/blk_guard_view.sv
// Module: blk_guard_view
// Selects one block's state and forms its status word and permit.
// Assumes: lock-down enforcement by a low write-protect level is shown
// without delay, so a falling level protects blocks in the same cycle.
module blk_guard_view #(
    parameter int N_BLK  = 71,
    parameter int IDX_W  = 7,
    parameter int STAT_W = 16
) (
    input  logic [N_BLK-1:0]  lock_q,
    input  logic [N_BLK-1:0]  ld_q,
    input  logic              wp_level,
    input  logic              vpp_lockout,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [STAT_W-1:0] stat_word,
    output logic              pe_ok
);

    logic [N_BLK-1:0] lock_eff;
    logic             hit, lk, ld;

    // Reported lock per block: stored bit, or forced by enforced lock-down.
    for (genvar i = 0; i < N_BLK; i++) begin : g_eff
        assign lock_eff[i] = lock_q[i] | (ld_q[i] & ~wp_level);
    end

    // Pick the queried block; an invalid index hits nothing.
    always_comb begin
        hit = 1'b0;
        lk  = 1'b0;
        ld  = 1'b0;
        for (int i = 0; i < N_BLK; i++) begin
            if (qry_idx == IDX_W'(i)) begin
                hit = 1'b1;
                lk  = lock_eff[i];
                ld  = ld_q[i];
            end
        end
    end

    // Status packing and permit decision.
    always_comb begin
        stat_word    = '0;
        stat_word[0] = hit & lk;
        stat_word[1] = hit & ld;
        pe_ok        = hit & ~lk & ~vpp_lockout;
    end

endmodule

// File: rtl/blk_guard.sv
// Module: blk_guard (top)
// Per-block protection manager for a boot-block flash array of
// N_PARAM parameter blocks plus N_MAIN main blocks.
// Assumes: requests are decoded upstream and strobed for one cycle;
// the lockout flag is a clean digital level.
module blk_guard
    import blk_guard_pkg::*;
#(
    parameter int N_PARAM = 8,
    parameter int N_MAIN  = 63,
    parameter int IDX_W   = 7,
    parameter int STAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              wp_level,
    input  logic              vpp_lockout,
    input  logic [IDX_W-1:0]  qry_idx,
    output logic [STAT_W-1:0] stat_word,
    output logic              pe_ok
);

    localparam int N_BLK = N_PARAM + N_MAIN;

    logic [N_BLK-1:0] sel;
    logic [N_BLK-1:0] lock_q;
    logic [N_BLK-1:0] ld_q;
    guard_op_t        op;

    // Request code to the typed op.
    assign op = guard_op_t'(req_op);

    blk_guard_sel #(.N_BLK(N_BLK), .IDX_W(IDX_W)) u_sel (
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .sel       (sel)
    );

    // One state cell per erase block.
    for (genvar i = 0; i < N_BLK; i++) begin : g_blk
        blk_guard_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel[i]),
            .op       (op),
            .wp_level (wp_level),
            .lock_q   (lock_q[i]),
            .ld_q     (ld_q[i])
        );
    end

    blk_guard_view #(.N_BLK(N_BLK), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_view (
        .lock_q      (lock_q),
        .ld_q        (ld_q),
        .wp_level    (wp_level),
        .vpp_lockout (vpp_lockout),
        .qry_idx     (qry_idx),
        .stat_word   (stat_word),
        .pe_ok       (pe_ok)
    );

    // R9: lockout refuses program/erase everywhere.
    a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_lockout |-> !pe_ok);

    // R8: permit only on an unlocked block.
    a_r8_permit_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        pe_ok |-> !stat_word[0]);

    // R10: only the two low status bits may be set.
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[STAT_W-1:2] == '0);

    // R11: invalid query reports nothing.
    a_r11_invalid_query: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(qry_idx) >= N_BLK) |-> (stat_word == '0 && !pe_ok));

    // R7: enforced lock-down always reports locked.
    a_r7_wp_low_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[1] && !wp_level) |-> stat_word[0]);

endmodule

// File: tb/sim_blk_guard.sv
// Bench for blk_guard: behavioural model updated every clock edge and
// compared with the design's outputs at every falling edge.
module sim_blk_guard;

    localparam int NB = 71;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [6:0]  req_idx = '0;
    logic        wp_level = 1'b0;
    logic        vpp_lockout = 1'b0;
    logic [6:0]  qry_idx = '0;
    logic [15:0] stat_word;
    logic        pe_ok;

    int    checks = 0;
    int    errors = 0;
    bit    armed  = 1'b0;
    bit    done   = 1'b0;
    string tag    = "R1";

    bit mlock [NB];
    bit mld   [NB];

    always #5 clk = ~clk;

    blk_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .wp_level(wp_level), .vpp_lockout(vpp_lockout),
        .qry_idx(qry_idx), .stat_word(stat_word), .pe_ok(pe_ok)
    );

    // Reference model: behavioural state per block.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                mlock[i] = 1'b1;
                mld[i]   = 1'b0;
            end
        end else begin
            if (req_valid && int'(req_idx) < NB) begin
                case (req_op)
                    2'b01: mlock[req_idx] = 1'b1;
                    2'b10: if (!(mld[req_idx] && !wp_level)) mlock[req_idx] = 1'b0;
                    2'b11: begin mlock[req_idx] = 1'b1; mld[req_idx] = 1'b1; end
                    default: ;
                endcase
            end
            for (int i = 0; i < NB; i++)
                if (mld[i] && !wp_level) mlock[i] = 1'b1;
        end
    end

    task automatic compare();
        logic [15:0] es;
        logic        ep;
        bit          l;
        es = '0;
        ep = 1'b0;
        if (int'(qry_idx) < NB) begin
            l = mlock[qry_idx] | (mld[qry_idx] & ~wp_level);
            es[0] = l;
            es[1] = mld[qry_idx];
            ep = !l && !vpp_lockout;
        end
        checks++;
        if (stat_word !== es || pe_ok !== ep) begin
            errors++;
            $display("FAIL %s idx=%0d stat=%h exp=%h pe=%b exp=%b",
                     tag, qry_idx, stat_word, es, pe_ok, ep);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic cyc(input bit v, input logic [1:0] op,
                       input int ridx, input int qidx);
        @(negedge clk);
        if (armed && rst_n) compare();
        req_valid = v;
        req_op    = op;
        req_idx   = 7'(ridx);
        qry_idx   = 7'(qidx);
    endtask

    task automatic req(input logic [1:0] op, input int idx);
        cyc(1'b1, op, idx, idx);
        cyc(1'b0, 2'b00, 0, idx);
    endtask

    task automatic look(input int idx);
        cyc(1'b0, 2'b00, 0, idx);
    endtask

    initial begin
        repeat (3) cyc(1'b0, 2'b00, 0, 0);
        rst_n = 1'b1;
        armed = 1'b1;

        // R1: every block locked, not locked down, no permit.
        tag = "R1";
        for (int i = 0; i < NB; i++) look(i);

        // R2/R8: lock and unlock at the seams and ends.
        tag = "R2";
        req(2'b10, 5);  look(5);
        req(2'b01, 5);  look(5);
        req(2'b10, 0);  req(2'b10, 7); req(2'b10, 8); req(2'b10, 70);
        tag = "R8";
        look(0); look(7); look(8); look(70); look(6);
        tag = "R2";
        req(2'b00, 70); look(70);

        // R12: neighbours untouched.
        tag = "R12";
        look(1); look(9); look(69);

        // R3: lock-down with write-protect low.
        tag = "R3";
        wp_level = 1'b0;
        req(2'b11, 8); look(8);

        // R5: ignored while protected.
        tag = "R5";
        req(2'b10, 8); look(8); req(2'b01, 8); look(8);

        // R6: free toggling when write-protect is high.
        tag = "R6";
        wp_level = 1'b1;
        look(8);
        req(2'b10, 8); look(8);
        req(2'b01, 8); look(8);
        req(2'b10, 8); look(8);

        // R7: falling write-protect re-locks immediately.
        tag = "R7";
        wp_level = 1'b0;
        look(8); look(8);
        wp_level = 1'b1; look(8);

        // R4: commands do not clear lock-down; reset does.
        tag = "R4";
        req(2'b10, 8); req(2'b01, 8); req(2'b10, 8); look(8);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look(8); look(70); look(0);

        // R9: lockout refuses an unlocked block.
        tag = "R9";
        req(2'b10, 3); look(3);
        vpp_lockout = 1'b1; look(3); look(3);
        vpp_lockout = 1'b0; look(3);

        // R11: invalid indices.
        tag = "R11";
        req(2'b10, 71); req(2'b11, 127); look(71); look(127);
        for (int i = 0; i < NB; i++) look(i);

        // R10: random traffic, layout checked on every compare.
        tag = "R10";
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 40) == 0) wp_level = ~wp_level;
            if ($urandom_range(0, 30) == 0) vpp_lockout = ~vpp_lockout;
            rst_n = ($urandom_range(0, 800) != 0);
            cyc($urandom_range(0, 2) != 0, 2'($urandom_range(0, 3)),
                $urandom_range(0, 127), $urandom_range(0, 80));
        end
        rst_n = 1'b1;
        look(0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule